// File: doc/BRIEF.md
# Multi-format stereo audio serial port

This block moves 16-bit stereo samples between a parallel interface and a three-wire audio serial link. The link has a bit clock, a frame clock and one data line in each direction. Outgoing words (`tx_left`, `tx_right`) are shifted out on `sdto`. Incoming bits on `sdti` are assembled into `rx_left` and `rx_right`. When the right word of a frame is delivered, `rx_valid` pulses for one cycle.

A 2-bit format select picks one of four framings. Two of them are asymmetric: the output word is left-aligned while the input word is right-aligned. A short-pulse framing has two modifier bits that move the first data bit by half a bit clock at a time.

In master mode the block divides its system clock to make the bit and frame clocks and drives them out. In slave mode it takes both clocks from the far end. In both modes the serial clocks are oversampled by the system clock through a two-stage synchronizer. Every serial event is therefore seen three system cycles after the pin changes, and the system clock must run at least eight times the bit clock.

Top module: `audio_serial_port`

## Requirements
- R1: After reset, `sdto`, `rx_valid`, `rx_left`, `rx_right`, `bclk_o` and `lrck_o` are all 0.
- R2: Format select values are: 0 pulse framing for both directions; 1 left-aligned output with right-aligned input; 2 left-aligned for both directions; 3 one-bit-delayed framing for both directions. Words travel MSB first as two's complement.
- R3: In formats 1 and 2 the frame clock is high for the left channel and changes together with a falling bit-clock edge. The MSB is driven at that same falling edge, later bits change on falling edges, and input bits are sampled on rising edges.
- R4: In format 3 the frame clock is low for the left channel, and the MSB is driven at the falling bit-clock edge one bit clock after the frame clock changes.
- R5: In format 1 the input word is taken from the last 16 bits received before the frame clock changes again.
- R6: In format 0 the MSB is launched at the first rising bit-clock edge after the frame clock rises. Setting `bckp` moves the launch half a bit later, setting `msbs` moves it another half bit later, and the input is sampled on the opposite edge just after each launch.
- R7: In format 0 the left word and then the right word follow back to back as 32 consecutive bits.
- R8: Bit slots beyond the data bits are driven 0 on `sdto`, and `sdti` values in such slots do not reach `rx_left` or `rx_right`.
- R9: `rx_valid` is a single-cycle pulse, once per frame, issued when the right word is delivered. The words of that frame are then present on `rx_left` and `rx_right`.
- R10: With `master` = 1 the block drives `bclk_o` and `lrck_o` with 64 bit clocks per frame and HALF_DIV system cycles per half bit clock, and the frame clock changes only at falling bit-clock edges. With `master` = 0 both outputs stay 0 and `bclk_i`/`lrck_i` are used.
- R11: `tx_left` and `tx_right` are sampled once at the start of each frame, so changing them mid-frame does not alter the frame already being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1 = generate serial clocks, 0 = accept them |
| fmt | input | 2 | Framing select (see R2) |
| bckp | input | 1 | Pulse framing: launch half a bit later |
| msbs | input | 1 | Pulse framing: launch a further half bit later |
| bclk_i | input | 1 | Bit clock from the far end (slave mode) |
| lrck_i | input | 1 | Frame clock from the far end (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrck_o | output | 1 | Generated frame clock (master mode) |
| sdti | input | 1 | Serial data in |
| sdto | output | 1 | Serial data out |
| tx_left | input | 16 | Left word to send |
| tx_right | input | 16 | Right word to send |
| rx_left | output | 16 | Last received left word |
| rx_right | output | 16 | Last received right word |
| rx_valid | output | 1 | One-cycle pulse when a frame is received |

## Verification
The hardest cases to reach are the four pulse-framing launch offsets. They differ only by half-bit shifts that a loose sampling point would hide. The bench therefore acts as the far end in slave mode and compares `sdto` at the end of every half bit of a whole frame against a model of where each bit must launch. Unused slots are filled with ones on `sdti`, so any capture outside the data window shows up as a wrong received word. Master mode is covered by looping `sdto` back into `sdti` and checking that the received words match the sent ones.

// File: rtl/asp_pkg.sv
package asp_pkg;

    typedef enum logic [1:0] {
        FMT_PULSE   = 2'd0,
        FMT_MSB_LSB = 2'd1,
        FMT_MSB     = 2'd2,
        FMT_DELAY1  = 2'd3
    } fmt_e;

endpackage

// File: rtl/asp_clkgen.sv
module asp_clkgen #(
    parameter int HALF_DIV = 4,
    parameter int SLOTS    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  asp_pkg::fmt_e fmt,
    output logic          bclk,
    output logic          lrck
);
    localparam int HC_W = $clog2(4 * SLOTS);
    localparam int DV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [DV_W-1:0] div;
        logic [HC_W-1:0] hc;
        logic            lr;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [HC_W-1:0] hc_n;

    always_comb begin
        gen_d = gen_q;
        hc_n  = gen_q.hc;
        if (!en) begin
            gen_d = '0;
        end else if (gen_q.div == DV_W'(HALF_DIV - 1)) begin
            gen_d.div = '0;
            hc_n = (gen_q.hc == HC_W'(4 * SLOTS - 1)) ? '0 : gen_q.hc + 1'b1;
            gen_d.hc = hc_n;
            if (!hc_n[0]) begin
                case (fmt)
                    asp_pkg::FMT_PULSE:  gen_d.lr = (hc_n < HC_W'(2));
                    asp_pkg::FMT_DELAY1: gen_d.lr = (hc_n >= HC_W'(2 * SLOTS));
                    default:             gen_d.lr = (hc_n < HC_W'(2 * SLOTS));
                endcase
            end
        end else begin
            gen_d.div = gen_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign bclk = gen_q.hc[0];
    assign lrck = gen_q.lr;

    // R10: frame clock moves only together with a falling bit clock
    p_frame_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (gen_q.lr != $past(gen_q.lr)))
            |-> (!gen_q.hc[0] && $past(gen_q.hc[0])));

endmodule

// File: rtl/asp_edge.sv
module asp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic lrck,
    input  logic sdti,
    output logic rise,
    output logic fall,
    output logic lr,
    output logic lr_chg,
    output logic lr_rise,
    output logic sd
);
    typedef struct packed {
        logic [2:0] bc;
        logic [2:0] lc;
        logic [1:0] sd;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.bc = {sy_q.bc[1:0], bclk};
        sy_d.lc = {sy_q.lc[1:0], lrck};
        sy_d.sd = {sy_q.sd[0], sdti};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign rise    = sy_q.bc[1] & ~sy_q.bc[2];
    assign fall    = ~sy_q.bc[1] & sy_q.bc[2];
    assign lr      = sy_q.lc[1];
    assign lr_chg  = sy_q.lc[1] ^ sy_q.lc[2];
    assign lr_rise = sy_q.lc[1] & ~sy_q.lc[2];
    assign sd      = sy_q.sd[1];

endmodule

// File: rtl/asp_engine.sv
module asp_engine #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  asp_pkg::fmt_e fmt,
    input  logic          bckp,
    input  logic          msbs,
    input  logic          rise,
    input  logic          fall,
    input  logic          lr,
    input  logic          lr_chg,
    input  logic          lr_rise,
    input  logic          sdti,
    input  logic [DW-1:0] tx_left,
    input  logic [DW-1:0] tx_right,
    output logic          sdto,
    output logic [DW-1:0] rx_left,
    output logic [DW-1:0] rx_right,
    output logic          rx_valid
);
    localparam int BW = $clog2(DW);

    typedef struct packed {
        logic          armed;
        logic          active;
        logic          chan;
        logic [CW-1:0] h;
        logic [DW-1:0] sh;
        logic [DW-1:0] txl;
        logic [DW-1:0] txr;
        logic [DW-1:0] rxl;
        logic [DW-1:0] rxr;
        logic          valid;
        logic          sdto;
    } eng_t;

    eng_t st_d, st_q;

    logic          is_pulse, start, evt, act, nchan, in_range, keep;
    logic [CW-1:0] h_now, off, rel;
    logic [CW-2:0] k;
    logic [DW-1:0] txl_n, txr_n, word, sh_n;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        is_pulse   = (fmt == asp_pkg::FMT_PULSE);
        evt        = rise | fall;
        start      = 1'b0;
        nchan      = (fmt == asp_pkg::FMT_DELAY1) ? lr : ~lr;
        txl_n      = st_q.txl;
        txr_n      = st_q.txr;

        // where a channel or frame begins
        if (is_pulse) begin
            if (lr_rise) begin
                st_d.armed  = 1'b1;
                st_d.active = 1'b0;
            end else if (st_q.armed && rise) begin
                start = 1'b1;
            end
        end else begin
            start = fall & lr_chg;
        end

        act   = start | (st_q.active & ~(is_pulse & lr_rise));
        h_now = start ? '0 :
                ((st_q.h == {CW{1'b1}}) ? st_q.h : st_q.h + 1'b1);

        if (start) begin
            st_d.active = 1'b1;
            st_d.armed  = 1'b0;
            st_d.h      = '0;
            if (is_pulse) begin
                st_d.chan = 1'b0;
                txl_n     = tx_left;
                txr_n     = tx_right;
            end else begin
                if (st_q.active) begin
                    if (st_q.chan) begin
                        st_d.rxr   = st_q.sh;
                        st_d.valid = 1'b1;
                    end else begin
                        st_d.rxl   = st_q.sh;
                    end
                end
                st_d.chan = nchan;
                if (!nchan) begin
                    txl_n = tx_left;
                    txr_n = tx_right;
                end
            end
        end else if (evt && st_q.active) begin
            st_d.h = h_now;
        end
        st_d.txl = txl_n;
        st_d.txr = txr_n;

        // half-edge position relative to the first launch
        if (is_pulse)                          off = CW'(bckp) + CW'(msbs);
        else if (fmt == asp_pkg::FMT_DELAY1)   off = CW'(2);
        else                                   off = '0;
        rel      = h_now - off;
        k        = rel[CW-1:1];
        in_range = is_pulse ? (k < (CW-1)'(2 * DW)) : (k < (CW-1)'(DW));
        word     = is_pulse ? (k[BW] ? txr_n : txl_n)
                            : (st_d.chan ? txr_n : txl_n);
        sh_n     = {st_q.sh[DW-2:0], sdti};
        keep     = in_range | (fmt == asp_pkg::FMT_MSB_LSB);

        if (act && evt && (h_now >= off)) begin
            if (!rel[0]) begin
                st_d.sdto = in_range ? word[BW'(DW - 1) - k[BW-1:0]] : 1'b0;
            end else if (keep) begin
                st_d.sh = sh_n;
                if (is_pulse && (k == (CW-1)'(DW - 1))) begin
                    st_d.rxl = sh_n;
                end
                if (is_pulse && (k == (CW-1)'(2 * DW - 1))) begin
                    st_d.rxr   = sh_n;
                    st_d.valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdto     = st_q.sdto;
    assign rx_left  = st_q.rxl;
    assign rx_right = st_q.rxr;
    assign rx_valid = st_q.valid;

    // R9: delivery strobe never lasts two cycles
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R9: a word is delivered only in response to a serial clock edge
    p_commit_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(rise || fall));

    // R3: serial output changes only after a bit-clock edge was seen
    p_sdto_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sdto != $past(st_q.sdto)) |-> $past(rise || fall));

    // R6: a pending pulse-framing start never coexists with a running frame
    p_armed_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> !st_q.active);

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
    parameter int DW       = 16,
    parameter int HALF_DIV = 4,
    parameter int SLOTS    = 32,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master,
    input  logic [1:0]    fmt,
    input  logic          bckp,
    input  logic          msbs,
    input  logic          bclk_i,
    input  logic          lrck_i,
    output logic          bclk_o,
    output logic          lrck_o,
    input  logic          sdti,
    output logic          sdto,
    input  logic [DW-1:0] tx_left,
    input  logic [DW-1:0] tx_right,
    output logic [DW-1:0] rx_left,
    output logic [DW-1:0] rx_right,
    output logic          rx_valid
);
    asp_pkg::fmt_e fmt_e;
    logic gen_b, gen_l, bclk_s, lrck_s;
    logic e_rise, e_fall, e_lr, e_lr_chg, e_lr_rise, e_sd;

    assign fmt_e = asp_pkg::fmt_e'(fmt);

    asp_clkgen #(.HALF_DIV(HALF_DIV), .SLOTS(SLOTS)) u_gen (
        .clk(clk), .rst_n(rst_n), .en(master), .fmt(fmt_e),
        .bclk(gen_b), .lrck(gen_l)
    );

    assign bclk_o = master & gen_b;
    assign lrck_o = master & gen_l;
    assign bclk_s = master ? gen_b : bclk_i;
    assign lrck_s = master ? gen_l : lrck_i;

    asp_edge u_edge (
        .clk(clk), .rst_n(rst_n), .bclk(bclk_s), .lrck(lrck_s), .sdti(sdti),
        .rise(e_rise), .fall(e_fall), .lr(e_lr), .lr_chg(e_lr_chg),
        .lr_rise(e_lr_rise), .sd(e_sd)
    );

    asp_engine #(.DW(DW), .CW(CW)) u_eng (
        .clk(clk), .rst_n(rst_n), .fmt(fmt_e), .bckp(bckp), .msbs(msbs),
        .rise(e_rise), .fall(e_fall), .lr(e_lr), .lr_chg(e_lr_chg),
        .lr_rise(e_lr_rise), .sdti(e_sd),
        .tx_left(tx_left), .tx_right(tx_right),
        .sdto(sdto), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

endmodule

// File: tb/sim_audio_serial_port.sv
`timescale 1ns/1ps
module sim_audio_serial_port;
    localparam int DW   = 16;
    localparam int HALF = 8;
    localparam int MDIV = 4;

    // {fmt, bckp, msbs, tx_left, tx_right, rx_left, rx_right}
    localparam logic [67:0] VEC [8] = '{
        {2'd0, 1'b0, 1'b0, 16'hA5C3, 16'h1E2F, 16'h8001, 16'h7FFE},
        {2'd0, 1'b1, 1'b0, 16'h0F0F, 16'hC001, 16'h1234, 16'hFEDC},
        {2'd0, 1'b0, 1'b1, 16'h8000, 16'h0001, 16'h5A5A, 16'h00FF},
        {2'd0, 1'b1, 1'b1, 16'h7FFF, 16'hFFFE, 16'hC3C3, 16'h0180},
        {2'd1, 1'b0, 1'b0, 16'h9C31, 16'h42E7, 16'h0007, 16'hE000},
        {2'd2, 1'b0, 1'b0, 16'h1357, 16'h8ACE, 16'hB00B, 16'h4004},
        {2'd3, 1'b0, 1'b0, 16'hDEAD, 16'h2468, 16'h8421, 16'h0F1E},
        {2'd3, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, master, bckp, msbs, bclk_i, lrck_i, sdti;
    logic [1:0] fmt;
    logic [DW-1:0] tx_left, tx_right;
    logic bclk_o, lrck_o, sdto, rx_valid;
    logic [DW-1:0] rx_left, rx_right;

    audio_serial_port #(.DW(DW), .HALF_DIV(MDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .master(master), .fmt(fmt), .bckp(bckp),
        .msbs(msbs), .bclk_i(bclk_i), .lrck_i(lrck_i), .bclk_o(bclk_o),
        .lrck_o(lrck_o), .sdti(sdti), .sdto(sdto), .tx_left(tx_left),
        .tx_right(tx_right), .rx_left(rx_left), .rx_right(rx_right),
        .rx_valid(rx_valid)
    );

    int checks = 0;
    int errors = 0;
    int vcnt   = 0;
    bit done   = 1'b0;

    always @(negedge clk) if (rx_valid === 1'b1) vcnt++;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int launch_idx(logic [1:0] f, int off, int hb);
        if (f == 2'd0) begin
            if (hb >= 1 + off && ((hb - 1 - off) % 2) == 0) return (hb - 1 - off) / 2;
            return -1;
        end
        if (hb % 2 == 0) return (hb % 64) / 2;
        return -1;
    endfunction

    function automatic logic frame_lr(logic [1:0] f, int hb);
        if (f == 2'd0) return (hb < 2);
        if (f == 2'd3) return (hb >= 64);
        return (hb < 64);
    endfunction

    function automatic logic out_bit(logic [1:0] f, int hb, int idx, logic [15:0] l, logic [15:0] r, logic hold);
        logic [15:0] w;
        if (f == 2'd0) begin
            if (idx < 16) return l[15 - idx];
            if (idx < 32) return r[31 - idx];
            return 1'b0;
        end
        w = (hb >= 64) ? r : l;
        if (f == 2'd3) begin
            if (idx == 0) return hold;
            if (idx <= 16) return w[16 - idx];
            return 1'b0;
        end
        if (idx < 16) return w[15 - idx];
        return 1'b0;
    endfunction

    function automatic logic in_bit(logic [1:0] f, int hb, int idx, logic [15:0] l, logic [15:0] r);
        logic [15:0] w;
        if (f == 2'd0) begin
            if (idx < 16) return l[15 - idx];
            if (idx < 32) return r[31 - idx];
            return 1'b1;
        end
        w = (hb >= 64) ? r : l;
        if (f == 2'd1) return (idx >= 16) ? w[31 - idx] : 1'b1;
        if (f == 2'd2) return (idx < 16) ? w[15 - idx] : 1'b1;
        if (idx >= 1 && idx <= 16) return w[16 - idx];
        return 1'b1;
    endfunction

    function automatic string tag_of(logic [1:0] f);
        if (f == 2'd0) return "R6";
        if (f == 2'd1) return "R5";
        if (f == 2'd3) return "R4";
        return "R3";
    endfunction

    // bench acts as the far end in slave mode; compares sdto on the last frame
    task automatic run_frames(input logic [1:0] f, input logic b, input logic m,
                              input logic [15:0] tl, input logic [15:0] tr,
                              input logic [15:0] rl, input logic [15:0] rr,
                              input int nfr, input bit swap_tx, output int mism);
        logic exp_o;
        int off;
        exp_o = 1'b0;
        mism  = 0;
        off   = int'(b) + int'(m);
        @(negedge clk);
        fmt = f; bckp = b; msbs = m; tx_left = tl; tx_right = tr; master = 1'b0;
        for (int fr = 0; fr < nfr; fr++) begin
            for (int hb = 0; hb < 128; hb++) begin
                int idx;
                @(negedge clk);
                bclk_i = hb[0];
                lrck_i = frame_lr(f, hb);
                idx = launch_idx(f, off, hb);
                if (idx >= 0) begin
                    sdti  = in_bit(f, hb, idx, rl, rr);
                    exp_o = out_bit(f, hb, idx, tl, tr, exp_o);
                end
                if (swap_tx && fr == nfr - 1 && hb == 10) tx_left = ~tl;
                repeat (HALF - 1) @(negedge clk);
                if (fr == nfr - 1 && sdto !== exp_o) mism++;
            end
        end
        tx_left = tl;
    endtask

    initial begin
        int mism, v0;
        rst_n = 1'b0; master = 1'b0; fmt = 2'd2; bckp = 1'b0; msbs = 1'b0;
        bclk_i = 1'b0; lrck_i = 1'b0; sdti = 1'b0;
        tx_left = '0; tx_right = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        check(sdto === 1'b0 && rx_valid === 1'b0, "R1 sdto/rx_valid after reset",
              longint'({sdto, rx_valid}), 0);
        check(rx_left === '0 && rx_right === '0, "R1 rx words after reset",
              longint'({rx_left, rx_right}), 0);
        check(bclk_o === 1'b0 && lrck_o === 1'b0, "R10 serial clock outputs idle in slave",
              longint'({bclk_o, lrck_o}), 0);

        // table-driven formats; junk ones in unused slots (R8)
        for (int v = 0; v < 8; v++) begin
            logic [1:0] f;
            logic b, m;
            logic [15:0] tl, tr, rl, rr;
            {f, b, m, tl, tr, rl, rr} = VEC[v];
            v0 = vcnt;
            run_frames(f, b, m, tl, tr, rl, rr, 3, 1'b0, mism);
            check(mism == 0, $sformatf("%s/R2 serial output vector %0d mismatching half-bits", tag_of(f), v),
                  longint'(mism), 0);
            check(rx_left === rl, $sformatf("%s/R7/R8 rx_left vector %0d", tag_of(f), v),
                  longint'(rx_left), longint'(rl));
            check(rx_right === rr, $sformatf("%s/R7/R8 rx_right vector %0d", tag_of(f), v),
                  longint'(rx_right), longint'(rr));
            check((vcnt - v0) >= 2 && (vcnt - v0) <= 3, $sformatf("R9 valid pulses vector %0d", v),
                  longint'(vcnt - v0), 3);
        end

        // R11: mid-frame change of tx_left does not disturb the frame in flight
        run_frames(2'd2, 1'b0, 1'b0, 16'h3C96, 16'h5AA5, 16'h0102, 16'h0304, 3, 1'b1, mism);
        check(mism == 0, "R11 tx words latched at frame start", longint'(mism), 0);

        // R10: master mode with serial loopback
        begin
            logic pb, pl;
            int lr_rises, b_rises, hi_cnt;
            @(negedge clk);
            fmt = 2'd2; bckp = 1'b0; msbs = 1'b0;
            tx_left = 16'h6B29; tx_right = 16'h94D6;
            bclk_i = 1'b0; lrck_i = 1'b0;
            master = 1'b1;
            pb = 1'b0; pl = 1'b0; lr_rises = 0; b_rises = 0; hi_cnt = 0;
            for (int c = 0; c < 4 * 128 * MDIV + 64; c++) begin
                @(negedge clk);
                sdti = sdto;
                if (lrck_o && !pl) lr_rises++;
                if (lr_rises == 2) begin
                    if (bclk_o && !pb) b_rises++;
                    if (bclk_o) hi_cnt++;
                end
                pb = bclk_o; pl = lrck_o;
            end
            check(b_rises == 64, "R10 bit clocks per frame", longint'(b_rises), 64);
            check(hi_cnt == 64 * MDIV, "R10 bit clock high time per frame",
                  longint'(hi_cnt), longint'(64 * MDIV));
            check(rx_left === 16'h6B29, "R10 loopback left word", longint'(rx_left), 64'h6B29);
            check(rx_right === 16'h94D6, "R10 loopback right word", longint'(rx_right), 64'h94D6);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule